// File: doc/BRIEF.md
# Dual-Channel Serial Latch Loader

This block receives a serial command stream over three wires (serial clock, active-low select, serial data) and uses each command to update one of two 8-bit setting codes. A dual-channel programmable resistor uses it this way: each code picks one of 256 tap positions, where 0x00 is the bottom end of the ladder and 0xFF is the top tap. The block drives the codes to the analog side, together with a shutdown flag.

The three serial pins and the shutdown pin are asynchronous to the block clock. They are brought into the block clock domain through synchronizer stages. Edges on the serial clock and on the select line are then detected in that domain. While select is low, every rising serial clock edge shifts a 10-bit register. On the rising edge of select, the register is decoded:
- bit 8 chooses the channel;
- bits 7..0 become that channel's new code;
- bit 9 is ignored.

The bit that falls off the top of the register is driven out on a serial output so that several devices can be chained.

Top module: `dual_latch_loader`

## Requirements
- R1: A synchronous active-low reset sets both codes to 0x80, clears the shift register, and drives `ser_dout` and `shutdown` low.
- R2: While `ser_cs_n` is low, every rising `ser_clk` edge appends `ser_din` as the new bit 0, so the first bit of a 10-bit frame ends in bit 9. On the rising edge of `ser_cs_n`, bits 7..0 are loaded into the channel that bit 8 selects: 0 selects `code_ch1` and 1 selects `code_ch2`. The new code is visible from the third rising `clk` edge after the select edge is applied. A code never changes at any other time.
- R3: A frame changes at most one channel. The channel that is not selected keeps its value.
- R4: A frame may hold any number of bits, and only the last ten shifted in are decoded. With fewer than ten, the bits already in the register stay ahead of the new ones.
- R5: `ser_clk` edges while `ser_cs_n` is high shift nothing. A frame with no clocks therefore reloads the selected channel from the unchanged register.
- R6: Bit 9 of the frame has no effect on which channel is loaded or on the loaded code.
- R7: After each falling `ser_clk` edge inside a frame, `ser_dout` shows the bit that left bit 9 at the preceding rising edge. This is the serial input from ten serial clocks earlier. It is visible from the third rising `clk` edge after the serial clock falls. While `ser_cs_n` is high, `ser_dout` is held low.
- R8: `shutdown` equals the inverse of `shdn_n`, two rising `clk` edges later. Shutdown never alters the codes, and frames still load during shutdown.
- R9: The extreme codes 0x00 and 0xFF load without alteration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous to `clk` |
| ser_cs_n | input | 1 | Active-low frame select; its rising edge commits the frame |
| ser_din | input | 1 | Serial data, most significant bit first |
| shdn_n | input | 1 | Active-low shutdown request |
| ser_dout | output | 1 | Serial chain output of the bit leaving the register |
| code_ch1 | output | 8 | Setting code of channel 1 |
| code_ch2 | output | 8 | Setting code of channel 2 |
| shutdown | output | 1 | High while shutdown is requested |

## Verification
Each input change passes through two synchronizer flops and one edge flop before it takes effect.
- A code commit is due on the third rising `clk` edge after the select rise.
- A new `ser_dout` bit is due on the third edge after the serial clock falls.
- `shutdown` follows its pin after two edges.

The bench drives every input on a falling `clk` edge. Its scoreboard monitor pops each expected pair of codes, waits exactly three rising edges and samples on the next falling edge. The serial-output checks wait the same three edges, and the shutdown checks wait two. Serial half-periods of eight block clocks keep every result settled before the next stimulus.

// File: rtl/dll_pkg.sv
`timescale 1ns/1ps
// Package: dll_pkg
// Shared defaults for the dual-channel serial latch loader.
// Assumes a two-channel configuration; widths may be overridden on the top.
package dll_pkg;
    localparam int unsigned     DLL_CODE_W      = 8;
    localparam int unsigned     DLL_HDR_W       = 2;
    localparam int unsigned     DLL_SYNC_STAGES = 2;
    localparam logic [7:0]      DLL_RESET_CODE  = 8'h80;
endpackage

// File: rtl/dll_sync.sv
`timescale 1ns/1ps
// Module: dll_sync
// Brings a vector of asynchronous pins into the clk domain through a chain
// of STAGES flops per bit. Assumes STAGES >= 2 and that each bit is
// independent (no multi-bit coherence is needed by the consumer).
module dll_sync #(
    parameter int unsigned      WIDTH   = 1,
    parameter int unsigned      STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VEC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift each pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VEC;
            end
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/dll_edge.sv
`timescale 1ns/1ps
// Module: dll_edge
// Produces a one-clk pulse on one chosen transition of an already
// synchronized level. RISING selects the polarity; RST_LEVEL is the idle
// level so no false edge is reported right after reset.
module dll_edge #(
    parameter logic RISING    = 1'b1,
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);

    logic prev_q;

    // Remember the level seen one clk earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= RST_LEVEL;
        end else begin
            prev_q <= level;
        end
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = level & ~prev_q;
        end else begin : g_fall
            assign pulse = ~level & prev_q;
        end
    endgenerate

endmodule

// File: rtl/dll_shift_reg.sv
`timescale 1ns/1ps
// Module: dll_shift_reg
// Serial command register. Shifts din in at bit 0 on each shift_en pulse.
// The bit leaving the top is parked in a spill flop and presented on dout
// at the next fall_en pulse. dout is forced low while idle is high.
// Only the low KEEP_W bits are exported for decoding. Assumes KEEP_W < WIDTH.
module dll_shift_reg #(
    parameter int unsigned WIDTH  = 10,
    parameter int unsigned KEEP_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              fall_en,
    input  logic              idle,
    input  logic              din,
    output logic [KEEP_W-1:0] keep_bits,
    output logic              dout
);

    logic [WIDTH-1:0] sh_q;
    logic             spill_q;
    logic             dout_q;

    // Append the incoming bit; older bits move towards the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (shift_en) begin
            sh_q <= {sh_q[WIDTH-2:0], din};
        end
    end

    // Capture the bit pushed out of the top on the same shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spill_q <= 1'b0;
        end else if (shift_en) begin
            spill_q <= sh_q[WIDTH-1];
        end
    end

    // Present the spilled bit on the serial clock fall; quiet when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
        end else if (idle) begin
            dout_q <= 1'b0;
        end else if (fall_en) begin
            dout_q <= spill_q;
        end
    end

    assign keep_bits = sh_q[KEEP_W-1:0];
    assign dout      = dout_q;

endmodule

// File: rtl/dll_latch_bank.sv
`timescale 1ns/1ps
// Module: dll_latch_bank
// NUM_CH setting-code registers. On a load pulse, exactly the register whose
// index equals sel takes data; all others hold. Assumes sel < NUM_CH.
module dll_latch_bank #(
    parameter int unsigned       CODE_W     = 8,
    parameter int unsigned       NUM_CH     = 2,
    parameter logic [CODE_W-1:0] RESET_CODE = 8'h80
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load,
    input  logic [$clog2(NUM_CH)-1:0]      sel,
    input  logic [CODE_W-1:0]              data,
    output logic [NUM_CH-1:0][CODE_W-1:0]  codes
);

    localparam int unsigned SEL_W = $clog2(NUM_CH);

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            logic [CODE_W-1:0] code_q;

            // Load this channel only when the frame addresses it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    code_q <= RESET_CODE;
                end else if (load && (sel == SEL_W'(g))) begin
                    code_q <= data;
                end
            end

            assign codes[g] = code_q;
        end
    endgenerate

endmodule

// File: rtl/dual_latch_loader.sv
`timescale 1ns/1ps
// Module: dual_latch_loader
// Serial front end of a dual-channel setting store. Synchronizes the serial
// pins to clk, shifts a WORD_W-bit command while select is low, and on the
// select rise writes the code field into the channel chosen by the bit
// above it. Assumes serial half-periods of several clk cycles.
module dual_latch_loader
    import dll_pkg::*;
#(
    parameter int unsigned       CODE_W      = DLL_CODE_W,
    parameter int unsigned       HDR_W       = DLL_HDR_W,
    parameter int unsigned       SYNC_STAGES = DLL_SYNC_STAGES,
    parameter logic [CODE_W-1:0] RESET_CODE  = CODE_W'(DLL_RESET_CODE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_cs_n,
    input  logic              ser_din,
    input  logic              shdn_n,
    output logic              ser_dout,
    output logic [CODE_W-1:0] code_ch1,
    output logic [CODE_W-1:0] code_ch2,
    output logic              shutdown
);

    localparam int unsigned NUM_CH   = 2;
    localparam int unsigned SEL_W    = $clog2(NUM_CH);
    localparam int unsigned KEEP_W   = CODE_W + SEL_W;
    localparam int unsigned WORD_W   = CODE_W + HDR_W;
    localparam logic [3:0]  SYNC_RST = 4'b1010;

    logic [3:0]                     raw_pins;
    logic [3:0]                     sync_pins;
    logic                           sclk_q;
    logic                           cs_q;
    logic                           din_q;
    logic                           shdn_q;
    logic                           sclk_rise;
    logic                           sclk_fall;
    logic                           cs_rise;
    logic                           cs_idle;
    logic                           shift_en;
    logic                           fall_en;
    logic                           frame_end;
    logic [KEEP_W-1:0]              kept;
    logic [NUM_CH-1:0][CODE_W-1:0]  codes;

    assign raw_pins = {shdn_n, ser_din, ser_cs_n, ser_clk};

    dll_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VEC (SYNC_RST)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_pins),
        .sync_out (sync_pins)
    );

    assign sclk_q = sync_pins[0];
    assign cs_q   = sync_pins[1];
    assign din_q  = sync_pins[2];
    assign shdn_q = sync_pins[3];

    dll_edge #(.RISING(1'b1), .RST_LEVEL(1'b0)) u_sclk_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sclk_q),
        .pulse (sclk_rise)
    );

    dll_edge #(.RISING(1'b0), .RST_LEVEL(1'b0)) u_sclk_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sclk_q),
        .pulse (sclk_fall)
    );

    dll_edge #(.RISING(1'b1), .RST_LEVEL(1'b1)) u_cs_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (cs_q),
        .pulse (cs_rise)
    );

    // Serial clock edges count only inside a frame.
    assign cs_idle   = cs_q;
    assign shift_en  = sclk_rise & ~cs_q;
    assign fall_en   = sclk_fall & ~cs_q;
    assign frame_end = cs_rise;

    dll_shift_reg #(
        .WIDTH  (WORD_W),
        .KEEP_W (KEEP_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .fall_en   (fall_en),
        .idle      (cs_idle),
        .din       (din_q),
        .keep_bits (kept),
        .dout      (ser_dout)
    );

    dll_latch_bank #(
        .CODE_W     (CODE_W),
        .NUM_CH     (NUM_CH),
        .RESET_CODE (RESET_CODE)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (frame_end),
        .sel   (kept[CODE_W +: SEL_W]),
        .data  (kept[CODE_W-1:0]),
        .codes (codes)
    );

    assign code_ch1 = codes[0];
    assign code_ch2 = codes[1];
    assign shutdown = ~shdn_q;

endmodule

// File: rtl/dll_checker.sv
`timescale 1ns/1ps
// Module: dll_checker
// Property checks for dual_latch_loader, attached through bind below.
// Observes the ports plus the frame-end pulse and the synchronized idle level.
module dll_checker #(
    parameter int unsigned       CODE_W     = 8,
    parameter logic [CODE_W-1:0] RESET_CODE = 8'h80
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] code_ch1,
    input logic [CODE_W-1:0] code_ch2,
    input logic              ser_dout,
    input logic              shutdown,
    input logic              shdn_n,
    input logic              frame_end,
    input logic              cs_idle
);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (code_ch1 == RESET_CODE && code_ch2 == RESET_CODE && !ser_dout && !shutdown)); // R1

    AST_LOAD_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (!$stable(code_ch1) || !$stable(code_ch2))) |-> $past(frame_end)); // R2

    AST_SINGLE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(code_ch1) || $stable(code_ch2))); // R3

    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cs_idle)) |-> !ser_dout); // R7

    AST_SHUTDOWN_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(shutdown)) |-> !$past(shdn_n)); // R8

    AST_SHUTDOWN_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(shutdown)) |-> $past(shdn_n)); // R8

endmodule

bind dual_latch_loader dll_checker #(
    .CODE_W     (CODE_W),
    .RESET_CODE (RESET_CODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_ch1  (code_ch1),
    .code_ch2  (code_ch2),
    .ser_dout  (ser_dout),
    .shutdown  (shutdown),
    .shdn_n    (shdn_n),
    .frame_end (frame_end),
    .cs_idle   (cs_idle)
);

// File: tb/dual_latch_loader_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard style. The frame driver pushes the expected pair of
// codes into a queue when it raises select. The monitor pops each item and
// compares it at the cycle the commit is due.
module dual_latch_loader_bench;

    localparam int HALF     = 8;   // serial half-period in clk cycles
    localparam int LOAD_DUE = 3;   // clk rises from select rise to code
    localparam int DOUT_DUE = 3;   // clk rises from serial fall to dout
    localparam int SHDN_DUE = 2;   // clk rises from pin to shutdown

    logic       clk      = 1'b0;
    logic       rst_n    = 1'b0;
    logic       ser_clk  = 1'b0;
    logic       ser_cs_n = 1'b1;
    logic       ser_din  = 1'b0;
    logic       shdn_n   = 1'b1;
    logic       ser_dout;
    logic [7:0] code_ch1;
    logic [7:0] code_ch2;
    logic       shutdown;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] e1;
        logic [7:0] e2;
    } exp_t;

    exp_t       sb_q[$];
    logic [9:0] mdl  = '0;      // expected register contents per R2/R4/R5
    logic [7:0] exp1 = 8'h80;
    logic [7:0] exp2 = 8'h80;

    always #2 clk = ~clk;

    dual_latch_loader u_dual_latch_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_cs_n (ser_cs_n),
        .ser_din  (ser_din),
        .shdn_n   (shdn_n),
        .ser_dout (ser_dout),
        .code_ch1 (code_ch1),
        .code_ch2 (code_ch2),
        .shutdown (shutdown)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    // One serial bit inside a frame; checks dout after the falling edge (R7).
    task automatic send_bit(input logic b);
        logic popped;
        popped  = mdl[9];
        ser_din = b;
        idle(HALF);
        ser_clk = 1'b1;
        mdl     = {mdl[8:0], b};
        idle(HALF);
        ser_clk = 1'b0;
        idle(DOUT_DUE);
        check("R7", "ser_dout", 32'(ser_dout), 32'(popped));
        idle(HALF - DOUT_DUE);
    endtask

    // Whole frame of n bits, most significant first; queues the expectation.
    task automatic send_frame(input logic [31:0] bits, input int n, input string tag);
        ser_cs_n = 1'b0;
        idle(HALF);
        for (int i = n - 1; i >= 0; i--) begin
            send_bit(bits[i]);
        end
        ser_cs_n = 1'b1;
        if (mdl[8]) exp2 = mdl[7:0];
        else        exp1 = mdl[7:0];
        sb_q.push_back('{tag, exp1, exp2});
        idle(HALF);
        check("R7", "ser_dout idle", 32'(ser_dout), 32'd0);
    endtask

    // Monitor: compare each queued expectation when its commit is due.
    initial begin
        exp_t item;
        forever begin
            wait (sb_q.size() > 0);
            item = sb_q.pop_front();
            repeat (LOAD_DUE) @(posedge clk);
            @(negedge clk);
            check(item.tag, "code_ch1", 32'(code_ch1), 32'(item.e1));
            check(item.tag, "code_ch2", 32'(code_ch2), 32'(item.e2));
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

    // Driver sequence.
    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(1);
        check("R1", "code_ch1", 32'(code_ch1), 32'h80);
        check("R1", "code_ch2", 32'(code_ch2), 32'h80);
        check("R1", "ser_dout", 32'(ser_dout), 32'd0);
        check("R1", "shutdown", 32'(shutdown), 32'd0);
        idle(HALF);

        send_frame(32'h05A, 10, "R2");          // ch1 <= 0x5A
        send_frame(32'h1C3, 10, "R3");          // ch2 <= 0xC3, ch1 kept
        send_frame(32'h200, 10, "R6");          // bit 9 set, ch1 <= 0x00 (R9)
        send_frame(32'h1FF, 10, "R9");          // ch2 <= 0xFF
        send_frame({7'd0, 15'h7ABC, 10'h096}, 25, "R4"); // last ten: ch1 <= 0x96
        send_frame(32'hB, 4, "R4");             // short frame: ch2 <= 0x6B
        send_frame(32'h03C, 10, "R2");          // ch1 <= 0x3C

        // R5: serial clocks with select high must not shift.
        ser_din = 1'b1;
        for (int k = 0; k < 5; k++) begin
            idle(HALF);
            ser_clk = 1'b1;
            idle(HALF);
            ser_clk = 1'b0;
        end
        idle(HALF);
        check("R7", "ser_dout idle clocks", 32'(ser_dout), 32'd0);
        check("R5", "code_ch1", 32'(code_ch1), 32'(exp1));
        check("R5", "code_ch2", 32'(code_ch2), 32'(exp2));
        send_frame(32'h0, 0, "R5");             // empty frame reloads ch1 0x3C

        // R8: shutdown follows the pin and leaves codes alone.
        shdn_n = 1'b0;
        idle(SHDN_DUE);
        check("R8", "shutdown on", 32'(shutdown), 32'd1);
        check("R8", "code_ch1", 32'(code_ch1), 32'(exp1));
        check("R8", "code_ch2", 32'(code_ch2), 32'(exp2));
        idle(HALF);
        send_frame(32'h121, 10, "R8");          // ch2 <= 0x21 during shutdown
        shdn_n = 1'b1;
        idle(SHDN_DUE);
        check("R8", "shutdown off", 32'(shutdown), 32'd0);
        check("R8", "code_ch2 kept", 32'(code_ch2), 32'h21);

        wait (sb_q.size() == 0);
        idle(LOAD_DUE + 3);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule